// File: doc/BRIEF.md
# Folded Lifting Wavelet Unit

This block computes the forward 9/7 wavelet transform of a single line of samples. It uses one lifting processing element, made of an adder pair and one multiplier, and reuses it over time. A line of up to `2*MAXP` samples arrives as even/odd pairs. The pairs are stored in a local even/odd buffer, and the transform then runs in place in two passes.

Each pass does a predict sweep over every odd slot and then an update sweep over every even slot. Pass 0 uses the first coefficient pair and pass 1 uses the second. Between passes only the coefficients change. A small controller sequences the phases, tracks the pass with one bit and steers every result back into the slot it came from. The same processing element then scales the buffer contents while it streams them out, giving one coefficient per cycle.

All arithmetic uses signed two's-complement fixed point with 12 fractional bits for the coefficients. Every lifting step and scaling product is rounded toward minus infinity.

Top module: `fold_dwt_lift`

## Requirements
- R1: While reset is held and after its release, `busy`, `out_valid` and `done` are low until a start is accepted.
- R2: A `start` seen while idle latches `len_pairs` = L (legal range 1..MAXP) and accepts exactly L pairs, one on each cycle with `in_valid` high. Pair i carries `in_even` = x[2i] and `in_odd` = x[2i+1]. Cycles with `in_valid` low are skipped.
- R3: Predict sweeps update odd slot o[i] += floor((e[i] + e[j]) * P / 4096) for i = 0..L-1, where j = i+1 clamped to L-1 (mirrored right edge). P = -6497 in pass 0 and P = 3616 in pass 1.
- R4: Update sweeps start only after the whole predict sweep of the same pass. Each does e[i] += floor((o[j] + o[i]) * U / 4096), where j = i-1 clamped to 0 (mirrored left edge). U = -217 in pass 0 and U = 1817 in pass 1.
- R5: Pass 1 runs after pass 0 on the same buffer contents, in the same order, with only the coefficient pair switched.
- R6: Readout emits 2L words on consecutive cycles. For i = 0..L-1 it emits the low-pass word of pair i (`out_band` = 0) and then the high-pass word of pair i (`out_band` = 1).
- R7: The low-pass word is floor(e[i] * 4709 / 4096) (scaling by K). The high-pass word is floor(o[i] * 3563 / 4096) (scaling by 1/K).
- R8: `done` is high for exactly one cycle, and that cycle is the one carrying the last high-pass word.
- R9: `busy` is high from the cycle after an accepted start through the cycle of `done`, and low in the cycle after `done`.
- R10: A `start` pulse while `busy` is high is ignored. The running line keeps its length and its results.
- R11: Full-scale inputs of either sign pass through all steps without wrap-around, using IW = DW+4 bit internal and output words.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new line (acted on only while idle) |
| len_pairs | input | $clog2(MAXP+1) | Line length in even/odd pairs |
| in_valid | input | 1 | Input pair present during load |
| in_even | input | DW | Even-phase sample |
| in_odd | input | DW | Odd-phase sample |
| busy | output | 1 | Unit occupied with a line |
| out_valid | output | 1 | Output word present |
| out_band | output | 1 | 0 = low-pass word, 1 = high-pass word |
| out_data | output | DW+4 | Scaled wavelet coefficient |
| done | output | 1 | Marks the final output word |

## Verification
The assertions assume that every accepted start carries a line length between 1 and MAXP. They also assume that input pairs are supplied only during the load phase; a checker flags any illegal length. The stimulus picks lengths only in that range, including both ends. It raises `in_valid` only while loading a line, with random gaps in between. Sample values are full-range signed numbers, plus directed full-scale and zero lines, so the widest growth of the lifting chain is covered.

// File: rtl/fold_dwt_pkg.sv
// Package: shared fixed-point constants and controller state type for the
// folded lifting wavelet unit. Assumes 12 fractional coefficient bits.
package fold_dwt_pkg;

    localparam int FW = 12;          // fractional bits of coefficients
    localparam int CW = FW + 3;      // signed coefficient width

    // Round a real coefficient to the nearest fixed-point integer.
    function automatic int qconv(real v);
        return $rtoi(v * real'(1 << FW) + ((v < 0.0) ? -0.5 : 0.5));
    endfunction

    localparam logic signed [CW-1:0] C_PRED0 = CW'(qconv(-1.586134342));
    localparam logic signed [CW-1:0] C_UPD0  = CW'(qconv(-0.052980118));
    localparam logic signed [CW-1:0] C_PRED1 = CW'(qconv(0.8829110762));
    localparam logic signed [CW-1:0] C_UPD1  = CW'(qconv(0.4435068522));
    localparam logic signed [CW-1:0] C_KLO   = CW'(qconv(1.149604398));
    localparam logic signed [CW-1:0] C_KHI   = CW'(qconv(1.0 / 1.149604398));

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PRED,
        ST_UPD,
        ST_OUT
    } fold_state_t;

endpackage

// File: rtl/fold_dwt_pe.sv
// Lifting processing element: res = base + floor((op_a + op_b) * coef / 2^FW).
// Purely combinational; assumes the caller sizes IW so no wrap occurs.
module fold_dwt_pe #(
    parameter int IW = 20,
    parameter int CW = 15,
    parameter int FW = 12
) (
    input  logic signed [IW-1:0] op_a,
    input  logic signed [IW-1:0] op_b,
    input  logic signed [IW-1:0] base,
    input  logic signed [CW-1:0] coef,
    output logic signed [IW-1:0] res
);
    localparam int SW = IW + 1;
    localparam int MW = SW + CW;

    logic signed [SW-1:0] nsum;
    logic signed [MW-1:0] prod;
    logic signed [MW-1:0] scaled;

    // Neighbour sum, coefficient product, floor shift and accumulate.
    always_comb begin
        nsum   = SW'(op_a) + SW'(op_b);
        prod   = MW'(nsum) * MW'(coef);
        scaled = prod >>> FW;
        res    = base + IW'(scaled);
    end

endmodule

// File: rtl/fold_dwt_ctrl.sv
// Pass sequencer: load -> (predict sweep, update sweep) x2 -> readout.
// Assumes len_pairs is in 1..MAXP when a start is accepted.
module fold_dwt_ctrl
    import fold_dwt_pkg::*;
#(
    parameter int MAXP = 32,
    parameter int IXW  = $clog2(MAXP),
    parameter int LW   = $clog2(MAXP + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [LW-1:0]  len_pairs,
    input  logic           in_valid,
    output fold_state_t    state_q,
    output logic [IXW-1:0] idx_q,
    output logic           pass_q,
    output logic           sub_q,
    output logic           last,
    output logic           busy,
    output logic           done
);
    logic [LW-1:0] len_q;

    // Index reaches the final pair of the current line.
    always_comb begin
        last = (LW'(idx_q) == (len_q - LW'(1)));
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_OUT) && sub_q && last;
    end

    // Phase, index, pass and band sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            pass_q  <= 1'b0;
            sub_q   <= 1'b0;
            len_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    len_q   <= len_pairs;
                    idx_q   <= '0;
                    pass_q  <= 1'b0;
                    sub_q   <= 1'b0;
                    state_q <= ST_LOAD;
                end
                ST_LOAD: if (in_valid) begin
                    if (last) begin
                        idx_q   <= '0;
                        state_q <= ST_PRED;
                    end else begin
                        idx_q <= idx_q + IXW'(1);
                    end
                end
                ST_PRED: begin
                    if (last) begin
                        idx_q   <= '0;
                        state_q <= ST_UPD;
                    end else begin
                        idx_q <= idx_q + IXW'(1);
                    end
                end
                ST_UPD: begin
                    if (last) begin
                        idx_q <= '0;
                        if (pass_q) begin
                            sub_q   <= 1'b0;
                            state_q <= ST_OUT;
                        end else begin
                            pass_q  <= 1'b1;
                            state_q <= ST_PRED;
                        end
                    end else begin
                        idx_q <= idx_q + IXW'(1);
                    end
                end
                ST_OUT: begin
                    if (sub_q) begin
                        sub_q <= 1'b0;
                        if (last) begin
                            idx_q   <= '0;
                            state_q <= ST_IDLE;
                        end else begin
                            idx_q <= idx_q + IXW'(1);
                        end
                    end else begin
                        sub_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Input assumption: accepted line length is legal.
    a_r2_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == ST_IDLE) |-> (len_pairs != '0 && len_pairs <= LW'(MAXP)));

    // Latched length never changes while a line is in flight (start ignored).
    a_r10_len_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(len_q));

    // Working index stays inside the line.
    a_r2_idx_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (LW'(idx_q) < len_q));

endmodule

// File: rtl/fold_dwt_lift.sv
// Top: folded forward 9/7 lifting over one line held in an even/odd buffer.
// One PE serves both passes and the output scaling. Assumes legal length.
module fold_dwt_lift
    import fold_dwt_pkg::*;
#(
    parameter int DW   = 16,
    parameter int MAXP = 32,
    parameter int IXW  = $clog2(MAXP),
    parameter int LW   = $clog2(MAXP + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [LW-1:0]          len_pairs,
    input  logic                   in_valid,
    input  logic signed [DW-1:0]   in_even,
    input  logic signed [DW-1:0]   in_odd,
    output logic                   busy,
    output logic                   out_valid,
    output logic                   out_band,
    output logic signed [DW+3:0]   out_data,
    output logic                   done
);
    localparam int GUARD = 4;
    localparam int IW    = DW + GUARD;

    fold_state_t      state_q;
    logic [IXW-1:0]   idx_q;
    logic             pass_q;
    logic             sub_q;
    logic             last;
    logic [IXW-1:0]   idx_right;
    logic [IXW-1:0]   idx_left;

    logic signed [IW-1:0] even_mem [MAXP];
    logic signed [IW-1:0] odd_mem  [MAXP];

    logic signed [IW-1:0] pe_a, pe_b, pe_base, pe_res;
    logic signed [CW-1:0] pe_coef;

    fold_dwt_ctrl #(.MAXP(MAXP), .IXW(IXW), .LW(LW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .len_pairs (len_pairs),
        .in_valid  (in_valid),
        .state_q   (state_q),
        .idx_q     (idx_q),
        .pass_q    (pass_q),
        .sub_q     (sub_q),
        .last      (last),
        .busy      (busy),
        .done      (done)
    );

    fold_dwt_pe #(.IW(IW), .CW(CW), .FW(FW)) u_pe (
        .op_a (pe_a),
        .op_b (pe_b),
        .base (pe_base),
        .coef (pe_coef),
        .res  (pe_res)
    );

    // Mirrored neighbour indices, clamped at both ends of the line.
    always_comb begin
        idx_right = last ? idx_q : (idx_q + IXW'(1));
        idx_left  = (idx_q == '0) ? '0 : (idx_q - IXW'(1));
    end

    // Operand and coefficient steering for the active phase and pass.
    always_comb begin
        pe_a    = '0;
        pe_b    = '0;
        pe_base = '0;
        pe_coef = '0;
        case (state_q)
            ST_PRED: begin
                pe_a    = even_mem[idx_q];
                pe_b    = even_mem[idx_right];
                pe_base = odd_mem[idx_q];
                pe_coef = pass_q ? C_PRED1 : C_PRED0;
            end
            ST_UPD: begin
                pe_a    = odd_mem[idx_left];
                pe_b    = odd_mem[idx_q];
                pe_base = even_mem[idx_q];
                pe_coef = pass_q ? C_UPD1 : C_UPD0;
            end
            ST_OUT: begin
                pe_a    = sub_q ? odd_mem[idx_q] : even_mem[idx_q];
                pe_coef = sub_q ? C_KHI : C_KLO;
            end
            default: ;
        endcase
    end

    // Buffer writes: line load, then in-place lifting results.
    always_ff @(posedge clk) begin
        if (state_q == ST_LOAD && in_valid) begin
            even_mem[idx_q] <= IW'(in_even);
            odd_mem[idx_q]  <= IW'(in_odd);
        end else if (state_q == ST_PRED) begin
            odd_mem[idx_q]  <= pe_res;
        end else if (state_q == ST_UPD) begin
            even_mem[idx_q] <= pe_res;
        end
    end

    // Output stream taken straight from the scaling PE.
    always_comb begin
        out_valid = (state_q == ST_OUT);
        out_band  = sub_q;
        out_data  = pe_res;
    end

    a_r6_high_follows_low: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_band) |=> (out_valid && out_band));

    a_r8_done_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_valid && out_band));

    a_r9_valid_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !out_valid));

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_valid && !done));

endmodule

// File: tb/test_fold_dwt_lift.sv
module test_fold_dwt_lift;
    localparam int DW   = 16;
    localparam int MAXP = 32;
    localparam int LW   = $clog2(MAXP + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [LW-1:0]        len_pairs = '0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_even = '0;
    logic signed [DW-1:0] in_odd = '0;
    logic                 busy, out_valid, out_band, done;
    logic signed [DW+3:0] out_data;

    int total = 0;
    int bad   = 0;

    longint xe [MAXP];
    longint xo [MAXP];
    longint ev [MAXP];
    longint od [MAXP];
    longint expw [2*MAXP];

    always #10 clk = ~clk;   // 50 MHz

    fold_dwt_lift #(.DW(DW), .MAXP(MAXP)) i_fold_dwt_lift (
        .clk(clk), .rst_n(rst_n), .start(start), .len_pairs(len_pairs),
        .in_valid(in_valid), .in_even(in_even), .in_odd(in_odd),
        .busy(busy), .out_valid(out_valid), .out_band(out_band),
        .out_data(out_data), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference transform built from the requirement formulas.
    task automatic compute_exp(input int n);
        for (int i = 0; i < n; i++) begin
            ev[i] = xe[i];
            od[i] = xo[i];
        end
        for (int p = 0; p < 2; p++) begin
            longint cp = (p == 0) ? -6497 : 3616;
            longint cu = (p == 0) ? -217 : 1817;
            for (int i = 0; i < n; i++) begin
                int j = (i == n - 1) ? i : i + 1;
                od[i] = od[i] + (((ev[i] + ev[j]) * cp) >>> 12);
            end
            for (int i = 0; i < n; i++) begin
                int j = (i == 0) ? 0 : i - 1;
                ev[i] = ev[i] + (((od[j] + od[i]) * cu) >>> 12);
            end
        end
        for (int i = 0; i < n; i++) begin
            expw[2*i]   = (ev[i] * 4709) >>> 12;
            expw[2*i+1] = (od[i] * 3563) >>> 12;
        end
    endtask

    task automatic run_line(input int n, input bit inject, input string tag);
        int  k = 0;
        bit  seen_done = 1'b0;
        compute_exp(n);
        @(negedge clk);
        start = 1'b1;
        len_pairs = LW'(n);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", longint'(busy), 1);
        for (int i = 0; i < n; ) begin
            if ($urandom % 4 == 0) begin
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
                in_even = DW'(xe[i]);
                in_odd  = DW'(xo[i]);
                i++;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_even = '0;
        in_odd = '0;
        if (inject) begin
            start = 1'b1;
            len_pairs = LW'((n % MAXP) + 1);
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R10 busy kept", longint'(busy), 1);
        end
        for (int c = 0; c < 2000 && !seen_done; c++) begin
            if (out_valid) begin
                longint act = out_data;
                chk(busy == 1'b1, "R9 busy during output", longint'(busy), 1);
                chk(out_band == k[0], "R6 band order", longint'(out_band), longint'(k % 2));
                chk(act == expw[k], tag, act, expw[k]);
                if (done) begin
                    chk(k == 2*n - 1, "R8 done position", k, 2*n - 1);
                    seen_done = 1'b1;
                end
                k++;
            end else begin
                chk(done == 1'b0, "R8 done without output", longint'(done), 0);
            end
            @(negedge clk);
        end
        chk(k == 2*n, "R2 R6 word count", k, 2*n);
        chk(busy == 1'b0, "R9 idle after done", longint'(busy), 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && out_valid == 1'b0 && done == 1'b0, "R1 in reset",
            longint'({busy, out_valid, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && out_valid == 1'b0 && done == 1'b0, "R1 after reset",
            longint'({busy, out_valid, done}), 0);

        // Directed: zeros, single pair, full length, full scale.
        for (int i = 0; i < MAXP; i++) begin xe[i] = 0; xo[i] = 0; end
        run_line(4, 1'b0, "R3 R4 R5 R7 zero line");
        xe[0] = 1000; xo[0] = -3000;
        run_line(1, 1'b0, "R3 R4 R7 single pair mirror");
        for (int i = 0; i < MAXP; i++) begin xe[i] = 32767; xo[i] = -32768; end
        run_line(MAXP, 1'b0, "R11 alternating full scale");
        for (int i = 0; i < MAXP; i++) begin xe[i] = -32768; xo[i] = 32767; end
        run_line(7, 1'b0, "R11 inverted full scale");
        for (int i = 0; i < MAXP; i++) begin xe[i] = 32767; xo[i] = 32767; end
        run_line(5, 1'b0, "R11 constant full scale");

        // Start while busy must not disturb the running line.
        for (int i = 0; i < MAXP; i++) begin
            xe[i] = longint'($signed(16'($urandom)));
            xo[i] = longint'($signed(16'($urandom)));
        end
        run_line(6, 1'b1, "R10 R3 R4 R5 R7 start ignored");

        // Random lines of random length.
        for (int t = 0; t < 12; t++) begin
            int n = int'($urandom % MAXP) + 1;
            for (int i = 0; i < MAXP; i++) begin
                xe[i] = longint'($signed(16'($urandom)));
                xo[i] = longint'($signed(16'($urandom)));
            end
            run_line(n, t[0], "R3 R4 R5 R7 random line");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule